// File: doc/BRIEF.md
# Erase Pin Qualification Controller

This block decides when a level on a shared erase pin is a deliberate request to wipe non-volatile storage. It runs on the slow clock of about 32.768 kHz. The pin first passes through a two-stage synchronizer. A counter then measures how long the pin has stayed high without a break. When the high time reaches a parameterised threshold, the block raises a single-cycle request. A sticky status flag records that a request went out, and software clears that flag by writing a one.

The pad can also serve as a general-purpose I/O. A mode bit held inside the block chooses between the two uses, and reset selects the erase function. While the pin is a general-purpose I/O, the block never issues a request, whatever level appears on the pad. A mode write takes effect in the same cycle as the write, so a count that is in progress is thrown away at once.

The default threshold is 5000 slow-clock cycles, about 153 ms. With that value, any pulse shorter than 100 ms is always rejected and any pulse longer than 220 ms is always accepted.

Top module: `erase_qual`

## Requirements
- R1: After reset, `gpio_mode_o` is 0 (erase function), `erase_req_o` is 0 and `erase_seen_o` is 0.
- R2: In erase mode, if `pin_i` is sampled high on `THRESH` consecutive rising edges, `erase_req_o` goes high for exactly one cycle. It rises on the second rising edge after the last of those samples. If there are only `THRESH-1` consecutive high samples, no request is made.
- R3: A high level of 3276 slow-clock cycles or fewer (under 100 ms) never produces a request.
- R4: A high level of 7210 slow-clock cycles or more (over 220 ms) always produces a request.
- R5: Any low sample restarts the high-time count, so two high stretches separated by a single low sample do not add together.
- R6: Each high episode gives at most one request, however long it lasts. Another request needs the pin to go low and then be high again for a full threshold.
- R7: Writing `cfg_we_i`=1 with `cfg_gpio_i`=1 selects general-purpose I/O, and `cfg_gpio_i`=0 selects erase. `gpio_mode_o` shows the selected mode. While general-purpose I/O is selected, `erase_req_o` stays 0.
- R8: Selecting general-purpose I/O in the middle of a count clears the count in that same cycle. After erase mode is selected again, a request needs `THRESH` new consecutive high samples.
- R9: `erase_seen_o` becomes 1 together with `erase_req_o` and stays 1 until `seen_clr_i`=1 is sampled. If a request and a clear arrive in the same cycle, the flag stays set.
- R10: A pin held low, including a pad driven low as an output, never produces a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slow clock, about 32.768 kHz |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Raw erase pad level (asynchronous) |
| cfg_we_i | input | 1 | Mode bit write strobe |
| cfg_gpio_i | input | 1 | Mode value written: 1 = general-purpose I/O, 0 = erase |
| seen_clr_i | input | 1 | Write-one-to-clear strobe for the status flag |
| erase_req_o | output | 1 | Single-cycle erase request |
| erase_seen_o | output | 1 | Sticky flag showing that a request was issued |
| gpio_mode_o | output | 1 | Current mode bit (1 = general-purpose I/O) |

## Verification
The bench drives the pin with high stretches of several lengths. One is exactly the threshold and one is a single cycle short, which locates the acceptance edge to the cycle. One sits at the 100 ms bound and one is past the 220 ms bound, which shows that the guaranteed windows are respected. A stretch broken by a single low sample separates a continuous measurement from a running total. A very long high stretch, followed by a fresh episode, separates one request per episode from repeated firing. Mode flips in the middle of a count, long runs in general-purpose I/O mode, and a status clear that lands on the same edge as a request show apart the gating and the set-over-clear priority.

// File: rtl/erase_qual_pkg.sv
package erase_qual_pkg;
  typedef enum logic {
    PIN_ERASE = 1'b0,
    PIN_GPIO  = 1'b1
  } pin_mode_e;
endpackage

// File: rtl/erase_sync.sv
module erase_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[i] <= 1'b0;
        else if (i == 0) chain_q[i] <= d_i;
        else chain_q[i] <= chain_q[(i > 0) ? i-1 : 0];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/erase_hold_cnt.sv
module erase_hold_cnt #(
  parameter int THRESH = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic clear_i,
  output logic full_o
);
  localparam int CW = (THRESH > 2) ? $clog2(THRESH) : 1;
  localparam logic [CW-1:0] LAST = CW'(THRESH - 1);

  logic [CW-1:0] cnt_q;

  // saturates at LAST; holds there until the level drops
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (clear_i || !lvl_i) cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign full_o = (cnt_q == LAST);
endmodule

// File: rtl/erase_req_gen.sv
module erase_req_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic full_i,
  input  logic block_i,
  input  logic clr_i,
  output logic req_o,
  output logic seen_o
);
  logic fired_q, req_q, seen_q, hit;

  assign hit = lvl_i && full_i && !block_i && !fired_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fired_q <= 1'b0;
      req_q   <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      req_q  <= hit;
      seen_q <= hit || (seen_q && !clr_i);  // set wins
      if (!lvl_i) fired_q <= 1'b0;
      else if (hit) fired_q <= 1'b1;
    end
  end

  assign req_o  = req_q;
  assign seen_o = seen_q;
endmodule

// File: rtl/erase_qual.sv
module erase_qual
  import erase_qual_pkg::*;
#(
  parameter int THRESH      = 5000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic cfg_we_i,
  input  logic cfg_gpio_i,
  input  logic seen_clr_i,
  output logic erase_req_o,
  output logic erase_seen_o,
  output logic gpio_mode_o
);
  pin_mode_e mode_q, mode_eff;
  logic      pin_s, full, blocked;

  // a write acts in its own cycle so a pending count dies at once
  assign mode_eff = cfg_we_i ? pin_mode_e'(cfg_gpio_i) : mode_q;
  assign blocked  = (mode_eff == PIN_GPIO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= PIN_ERASE;
    else mode_q <= mode_eff;
  end

  erase_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  erase_hold_cnt #(.THRESH(THRESH)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (pin_s),
    .clear_i(blocked),
    .full_o (full)
  );

  erase_req_gen u_req (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (pin_s),
    .full_i (full),
    .block_i(blocked),
    .clr_i  (seen_clr_i),
    .req_o  (erase_req_o),
    .seen_o (erase_seen_o)
  );

  assign gpio_mode_o = (mode_q == PIN_GPIO);
endmodule

// File: rtl/erase_qual_chk.sv
module erase_qual_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pin_i,
  input logic cfg_we_i,
  input logic cfg_gpio_i,
  input logic seen_clr_i,
  input logic erase_req_o,
  input logic erase_seen_o,
  input logic gpio_mode_o
);
  AST_REQ_SINGLE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_req_o |=> !erase_req_o); // R2
  AST_NO_REQ_IN_GPIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gpio_mode_o && erase_req_o)); // R7
  AST_REQ_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_req_o |-> erase_seen_o); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erase_seen_o && !seen_clr_i) |=> erase_seen_o); // R9
  AST_FLAG_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_clr_i |=> (!erase_seen_o || erase_req_o)); // R9
  AST_REQ_NEEDS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_req_o |-> $past(pin_i, 3)); // R10
endmodule

bind erase_qual erase_qual_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pin_i       (pin_i),
  .cfg_we_i    (cfg_we_i),
  .cfg_gpio_i  (cfg_gpio_i),
  .seen_clr_i  (seen_clr_i),
  .erase_req_o (erase_req_o),
  .erase_seen_o(erase_seen_o),
  .gpio_mode_o (gpio_mode_o)
);

// File: tb/tb_erase_qual.sv
module tb_erase_qual;
  localparam int THRESH = 5000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pin = 1'b0, cfg_we = 1'b0, cfg_gpio = 1'b0, clr = 1'b0;
  logic req, seen, gmode;
  int checks = 0, fails = 0, pulses = 0;

  always #2.5 clk = ~clk;

  erase_qual #(.THRESH(THRESH)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .cfg_we_i(cfg_we),
    .cfg_gpio_i(cfg_gpio), .seen_clr_i(clr), .erase_req_o(req),
    .erase_seen_o(seen), .gpio_mode_o(gmode)
  );

  // behavioural reference
  bit hist[$];
  int run = 0;
  bit m_fired = 0, m_req = 0, m_seen = 0, m_gpio = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist.delete(); run = 0; m_fired = 0; m_req = 0; m_seen = 0; m_gpio = 0;
    end else begin
      bit lvl, eff, hit;
      lvl = (hist.size() >= 2) ? hist[1] : 1'b0;
      hist.push_front(pin);
      if (hist.size() > 2) void'(hist.pop_back());
      eff = cfg_we ? cfg_gpio : m_gpio;
      hit = lvl && !eff && !m_fired && (run >= THRESH - 1);
      m_req  = hit;
      m_seen = hit || (m_seen && !clr);
      if (!lvl) m_fired = 0; else if (hit) m_fired = 1;
      if (eff || !lvl) run = 0; else run++;
      m_gpio = eff;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (req) pulses++;
    check("R2 req vs model", req, m_req);
    check("R9 seen vs model", seen, m_seen);
    check("R7 mode vs model", gmode, m_gpio);
  end

  task automatic hold(bit v, int n);
    pin = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic episode(string tag, int len, int exp);
    int base;
    base = pulses;
    hold(1'b1, len);
    hold(1'b0, 6);
    check(tag, pulses - base, exp);
  endtask

  task automatic set_mode(bit g);
    cfg_we = 1'b1; cfg_gpio = g;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 mode after reset", gmode, 0);
    check("R1 req after reset", req, 0);
    check("R1 seen after reset", seen, 0);

    episode("R2 one short of threshold", THRESH - 1, 0);
    episode("R2 exact threshold", THRESH, 1);
    check("R9 flag set", seen, 1);
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    check("R9 flag cleared", seen, 0);

    episode("R3 below 100ms", 3276, 0);
    episode("R4 above 220ms", 7210, 1);

    // R5: one low sample splits the stretch
    begin
      int base;
      base = pulses;
      hold(1'b1, THRESH - 1); hold(1'b0, 1); hold(1'b1, THRESH - 1); hold(1'b0, 6);
      check("R5 gap restarts count", pulses - base, 0);
    end

    episode("R6 long episode single pulse", 3 * THRESH, 1);
    episode("R6 new episode fires again", THRESH, 1);

    // R7
    set_mode(1'b1);
    check("R7 gpio selected", gmode, 1);
    episode("R7 no request in gpio", 8000, 0);

    // R8: flip to gpio mid count, back to erase while still high
    set_mode(1'b0);
    begin
      int base;
      base = pulses;
      pin = 1'b1;
      repeat (THRESH - 10) @(negedge clk);
      cfg_we = 1'b1; cfg_gpio = 1'b1; @(negedge clk);
      cfg_gpio = 1'b0; @(negedge clk);
      cfg_we = 1'b0;
      repeat (THRESH - 2) @(negedge clk);
      check("R8 count restarted", pulses - base, 0);
      repeat (8) @(negedge clk);
      check("R8 fires after fresh threshold", pulses - base, 1);
      hold(1'b0, 6);
    end

    // R9: clear on the same edge as the request
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    pin = 1'b1;
    repeat (THRESH + 1) @(negedge clk);
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    check("R9 req on clear edge", req, 1);
    check("R9 set beats clear", seen, 1);
    hold(1'b0, 6);

    episode("R10 pin held low", 0, 0);
    begin
      int base;
      base = pulses;
      hold(1'b0, 10000);
      check("R10 long low no request", pulses - base, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule